// File: doc/BRIEF.md
# BCD Calendar Clock

This block keeps wall-clock time and calendar date in packed BCD. A slow reference clock, presented as a one-cycle enable pulse in the system clock domain, is divided down to a one-second tick by two cascaded programmable counters. The first counter is the fine divider. The second counter counts wraps of the first. On each tick the seconds advance. Carries ripple through minutes, 24-hour hours, the day of the week, the day of the month, the month and a two-digit year. The day-of-month limit follows the month length, and February gets an extra day in leap years.

Software reaches the block through plain write and read strobes on three words: time, date and divider. All writes are accepted only while the configuration input is high. While that input is high, counting stops and both dividers are held at zero. When it drops, counting restarts from the loaded values. The block moves no data stream, so there is no valid/ready handshake. The write strobe takes effect on the clock edge it is sampled at, it never stalls, and the read port is combinational.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the time word reads 0x00000000, the date word reads 0x00002101 (year 00, weekday 1, month 01, day 01) and the divider word reads 0x007F00FF.
- R2: A seconds tick occurs once every (F+1)*(C+1) reference pulses. F is the fine divider, in divider word bits 22:16. C is the coarse divider, in bits 14:0. The reset values give exactly 32768 pulses per tick.
- R3: Each tick raises `sec_tick` for exactly one clock cycle. In that same cycle the time word shows the incremented seconds. Seconds count 00..59 in BCD and carry into the minutes at 59.
- R4: Minutes count 00..59 and carry into the hours. Hours count 00..23, and 23:59:59 rolls to 00:00:00 and advances the date.
- R5: The weekday counts 1..7 and moves from 7 to 1 on every day change.
- R6: Months 04, 06, 09 and 11 end after day 30. Months 01, 03, 05, 07, 08, 10 and 12 end after day 31. The day then restarts at 01 and the month advances.
- R7: February ends after day 29 when the two-digit year is divisible by 4, including 00, and after day 28 otherwise.
- R8: Month 12 rolls to 01 and advances the year, and year 99 rolls to 00.
- R9: A write while `cfg_mode` is low changes no word.
- R10: While `cfg_mode` is high, time and date do not change and no tick occurs. The first tick after `cfg_mode` falls comes one full period later.
- R11: Addresses are 0 for time, 1 for date, 2 for the divider, and 3 reads as zero. In the time word, hour tens are in bits 21:20, hour units in 19:16, minute tens in 14:12, minute units in 11:8, second tens in 6:4 and second units in 3:0. In the date word, year tens are in bits 23:20, year units in 19:16, the weekday in 15:13, month tens in bit 12, month units in 11:8, day tens in 5:4 and day units in 3:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | One pulse per reference clock period |
| cfg_mode | input | 1 | High: configuration mode, writes allowed, counting stopped |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write word select |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word select |
| rd_data | output | 32 | Read data, combinational |
| sec_tick | output | 1 | One-cycle pulse per seconds increment |

## Verification
The assertions watch, cycle by cycle, the local stepping rules. After every tick both dividers restart from zero, and config mode holds them at zero. A non-wrapping second leaves minutes and hours alone. A full minute wrap clears the lower fields and moves the hour. Time and date stay frozen without a tick or a load. The weekday and year wrap at their limits, and the divider word never changes outside config mode. Only the bench scenarios can show the exact tick period for several divider settings and gated reference pulses. The same holds for month lengths across the whole year, the leap-year February rule, and the delay of the first tick after config mode ends.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;

  localparam logic [1:0] ADDR_TIME = 2'd0;
  localparam logic [1:0] ADDR_DATE = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;

  // increment a two-digit BCD value
  function automatic logic [7:0] bcd_inc2(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // two-digit BCD year divisible by four: (2*tens + units) mod 4 == 0
  function automatic logic is_leap(input logic [7:0] y);
    logic [1:0] r;
    r = {y[4], 1'b0} + y[1:0];
    return (r == 2'd0);
  endfunction

  // last day of a BCD month, in BCD
  function automatic logic [7:0] month_last(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
`timescale 1ns/1ps
module cal_prescaler #(
  parameter int FINE_W   = 7,
  parameter int COARSE_W = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_en,
  input  logic                hold,
  input  logic [FINE_W-1:0]   fine_div,
  input  logic [COARSE_W-1:0] coarse_div,
  output logic                tick
);

  logic [FINE_W-1:0]   fine_cnt;
  logic [COARSE_W-1:0] coarse_cnt;
  logic                fine_wrap;

  assign fine_wrap = ref_en && (fine_cnt == fine_div);
  assign tick      = fine_wrap && !hold && (coarse_cnt == coarse_div);

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      fine_cnt   <= '0;
      coarse_cnt <= '0;
    end else if (ref_en) begin
      if (fine_wrap) begin
        fine_cnt <= '0;
        if (coarse_cnt == coarse_div) coarse_cnt <= '0;
        else                          coarse_cnt <= coarse_cnt + 1'b1;
      end else begin
        fine_cnt <= fine_cnt + 1'b1;
      end
    end
  end

  // R2
  psc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (fine_cnt == '0) && (coarse_cnt == '0));

  // R10
  psc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (fine_cnt == '0) && (coarse_cnt == '0));

endmodule

// File: rtl/cal_time.sv
`timescale 1ns/1ps
module cal_time (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        load,
  input  logic [31:0] load_word,
  output logic [31:0] time_word,
  output logic        day_step
);
  import cal_pkg::*;

  logic [7:0] sec_q, min_q, hr_q;

  assign day_step  = tick && (sec_q == 8'h59) && (min_q == 8'h59) && (hr_q == 8'h23);
  assign time_word = {10'd0, hr_q[5:0], 1'b0, min_q[6:0], 1'b0, sec_q[6:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= 8'h00;
      min_q <= 8'h00;
      hr_q  <= 8'h00;
    end else if (load) begin
      sec_q <= {1'b0, load_word[6:0]};
      min_q <= {1'b0, load_word[14:8]};
      hr_q  <= {2'b0, load_word[21:16]};
    end else if (tick) begin
      if (sec_q == 8'h59) begin
        sec_q <= 8'h00;
        if (min_q == 8'h59) begin
          min_q <= 8'h00;
          hr_q  <= (hr_q == 8'h23) ? 8'h00 : bcd_inc2(hr_q);
        end else begin
          min_q <= bcd_inc2(min_q);
        end
      end else begin
        sec_q <= bcd_inc2(sec_q);
      end
    end
  end

  // R3
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && sec_q != 8'h59) |=>
      (sec_q != $past(sec_q)) && $stable(min_q) && $stable(hr_q));

  // R4
  min_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && sec_q == 8'h59 && min_q == 8'h59 && hr_q != 8'h23) |=>
      (sec_q == 8'h00) && (min_q == 8'h00) && (hr_q != $past(hr_q)));

  // R10
  time_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(time_word));

endmodule

// File: rtl/cal_date.sv
`timescale 1ns/1ps
module cal_date (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic        load,
  input  logic [31:0] load_word,
  output logic [31:0] date_word
);
  import cal_pkg::*;

  logic [7:0] yr_q, mon_q, day_q;
  logic [2:0] wday_q;
  logic       month_end;

  assign month_end = (day_q == month_last(mon_q, is_leap(yr_q)));
  assign date_word = {8'd0, yr_q, wday_q, mon_q[4:0], 2'b0, day_q[5:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      yr_q   <= 8'h00;
      wday_q <= 3'd1;
      mon_q  <= 8'h01;
      day_q  <= 8'h01;
    end else if (load) begin
      yr_q   <= load_word[23:16];
      wday_q <= load_word[15:13];
      mon_q  <= {3'b0, load_word[12:8]};
      day_q  <= {2'b0, load_word[5:0]};
    end else if (step) begin
      wday_q <= (wday_q == 3'd7) ? 3'd1 : wday_q + 3'd1;
      if (month_end) begin
        day_q <= 8'h01;
        if (mon_q == 8'h12) begin
          mon_q <= 8'h01;
          yr_q  <= (yr_q == 8'h99) ? 8'h00 : bcd_inc2(yr_q);
        end else begin
          mon_q <= bcd_inc2(mon_q);
        end
      end else begin
        day_q <= bcd_inc2(day_q);
      end
    end
  end

  // R5
  wday_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && wday_q == 3'd7) |=> (wday_q == 3'd1));

  // R8
  year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && yr_q == 8'h99 && mon_q == 8'h12 && day_q == 8'h31) |=>
      (yr_q == 8'h00) && (mon_q == 8'h01) && (day_q == 8'h01));

  // R10
  date_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(date_word));

endmodule

// File: rtl/bcd_calendar.sv
`timescale 1ns/1ps
module bcd_calendar #(
  parameter int          FINE_W      = 7,
  parameter int          COARSE_W    = 15,
  parameter int unsigned FINE_RST    = 127,
  parameter int unsigned COARSE_RST  = 255,
  parameter int          FINE_LSB    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_en,
  input  logic        cfg_mode,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        sec_tick
);
  import cal_pkg::*;

  localparam logic [FINE_W-1:0]   FINE_INIT   = FINE_W'(FINE_RST);
  localparam logic [COARSE_W-1:0] COARSE_INIT = COARSE_W'(COARSE_RST);

  logic [FINE_W-1:0]   fine_q;
  logic [COARSE_W-1:0] coarse_q;
  logic                wr_ok, tick, day_step, sec_tick_q;
  logic [31:0]         time_word, date_word, div_word;

  assign wr_ok    = wr_en && cfg_mode;
  assign div_word = (32'(fine_q) << FINE_LSB) | 32'(coarse_q);
  assign sec_tick = sec_tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fine_q     <= FINE_INIT;
      coarse_q   <= COARSE_INIT;
      sec_tick_q <= 1'b0;
    end else begin
      sec_tick_q <= tick;
      if (wr_ok && wr_addr == ADDR_DIV) begin
        fine_q   <= wr_data[FINE_LSB +: FINE_W];
        coarse_q <= wr_data[COARSE_W-1:0];
      end
    end
  end

  cal_prescaler #(.FINE_W(FINE_W), .COARSE_W(COARSE_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .hold(cfg_mode),
    .fine_div(fine_q), .coarse_div(coarse_q), .tick(tick)
  );

  cal_time u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .load(wr_ok && wr_addr == ADDR_TIME), .load_word(wr_data),
    .time_word(time_word), .day_step(day_step)
  );

  cal_date u_date (
    .clk(clk), .rst_n(rst_n), .step(day_step),
    .load(wr_ok && wr_addr == ADDR_DATE), .load_word(wr_data),
    .date_word(date_word)
  );

  always_comb begin
    case (rd_addr)
      ADDR_TIME: rd_data = time_word;
      ADDR_DATE: rd_data = date_word;
      ADDR_DIV:  rd_data = div_word;
      default:   rd_data = 32'd0;
    endcase
  end

  // R9
  div_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> $stable(div_word));

  // R3
  tick_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> !$stable(time_word));

endmodule

// File: tb/sim_bcd_calendar.sv
`timescale 1ns/1ps
module sim_bcd_calendar;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_en = 1'b1;
  logic        gate = 1'b0;
  logic        cfg_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [31:0] rd_data;
  logic        sec_tick;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  always @(negedge clk) ref_en <= gate ? ~ref_en : 1'b1;

  bcd_calendar u0 (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .cfg_mode(cfg_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sec_tick(sec_tick)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  // returns at the negedge where sec_tick is seen high
  task automatic wait_tick(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!sec_tick && cyc < 100000);
  endtask

  // R1, R2, R3: reset values and default period
  task automatic t_reset;
    logic [31:0] d;
    int cyc;
    repeat (3) @(negedge clk);
    rd(2'd0, d); check("R1 time", d, 32'h0000_0000);
    rd(2'd1, d); check("R1 date", d, 32'h0000_2101);
    rd(2'd2, d); check("R1 divider", d, 32'h007F_00FF);
    rd(2'd3, d); check("R11 unused address", d, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    wait_tick(cyc);
    cfg_mode = 1'b1;
    check("R2 default period", cyc, 32768);
    rd(2'd0, d); check("R3 first second", d, 32'h0000_0001);
    @(negedge clk); check("R3 pulse width", {31'd0, sec_tick}, 32'd0);
  endtask

  // R9: writes outside config mode
  task automatic t_ignore;
    logic [31:0] d;
    cfg_mode = 1'b0;
    wr(2'd0, 32'h0012_3456);
    wr(2'd1, 32'h0055_A915);
    wr(2'd2, 32'h0001_0001);
    @(negedge clk); cfg_mode = 1'b1;
    rd(2'd0, d); check("R9 time kept", d, 32'h0000_0001);
    rd(2'd1, d); check("R9 date kept", d, 32'h0000_2101);
    rd(2'd2, d); check("R9 divider kept", d, 32'h007F_00FF);
  endtask

  // R10: freeze in config and first tick one period after exit
  task automatic t_freeze;
    logic [31:0] d;
    int cyc;
    int seen;
    wr(2'd2, 32'h0001_0001);
    rd(2'd2, d); check("R11 divider readback", d, 32'h0001_0001);
    wr(2'd0, 32'h0000_0010);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sec_tick) seen++;
    end
    check("R10 no tick in config", seen, 0);
    rd(2'd0, d); check("R10 time frozen", d, 32'h0000_0010);
    cfg_mode = 1'b0;
    wait_tick(cyc);
    check("R10 first tick delay", cyc, 4);
    wait_tick(cyc);
    cfg_mode = 1'b1;
    check("R2 period 2x2", cyc, 4);
    rd(2'd0, d); check("R3 two seconds", d, 32'h0000_0012);
  endtask

  // R2: gated reference pulses, divider 3x4
  task automatic t_gated;
    int cyc;
    wr(2'd2, 32'h0002_0003);
    gate = 1'b1;
    @(negedge clk); cfg_mode = 1'b0;
    wait_tick(cyc);
    wait_tick(cyc);
    cfg_mode = 1'b1;
    gate = 1'b0;
    check("R2 gated period", cyc, 24);
    wr(2'd2, 32'h0001_0001);
  endtask

  task automatic roll(input string req, input logic [31:0] t_in, input logic [31:0] d_in,
                      input logic [31:0] t_exp, input logic [31:0] d_exp);
    logic [31:0] d;
    int cyc;
    cfg_mode = 1'b1;
    wr(2'd0, t_in);
    wr(2'd1, d_in);
    @(negedge clk); cfg_mode = 1'b0;
    wait_tick(cyc);
    cfg_mode = 1'b1;
    rd(2'd0, d); check({req, " time"}, d, t_exp);
    rd(2'd1, d); check({req, " date"}, d, d_exp);
  endtask

  task automatic t_time_carry;
    roll("R4 minute carry", 32'h0000_5959, 32'h0000_2101, 32'h0001_0000, 32'h0000_2101);
    roll("R4 hour tens",    32'h0009_5959, 32'h0000_2101, 32'h0010_0000, 32'h0000_2101);
    roll("R3 second tens",  32'h0012_3409, 32'h0000_2101, 32'h0012_3410, 32'h0000_2101);
  endtask

  task automatic t_months;
    roll("R6 april 30",  32'h0023_5959, 32'h0021_6430, 32'h0, 32'h0021_8501);
    roll("R6 january 30", 32'h0023_5959, 32'h0021_4130, 32'h0, 32'h0021_6131);
    roll("R6 january 31", 32'h0023_5959, 32'h0021_4131, 32'h0, 32'h0021_6201);
    roll("R6 september", 32'h0023_5959, 32'h0021_A930, 32'h0, 32'h0021_D001);
    roll("R6 november",  32'h0023_5959, 32'h0021_3130, 32'h0, 32'h0021_5201);
  endtask

  task automatic t_feb;
    roll("R7 leap 28",   32'h0023_5959, 32'h0024_C228, 32'h0, 32'h0024_E229);
    roll("R7 leap 29",   32'h0023_5959, 32'h0024_E229, 32'h0, 32'h0024_2301);
    roll("R7 common 28", 32'h0023_5959, 32'h0023_8228, 32'h0, 32'h0023_A301);
    roll("R7 year 00",   32'h0023_5959, 32'h0000_2228, 32'h0, 32'h0000_4229);
  endtask

  task automatic t_year;
    roll("R8 new year",  32'h0023_5959, 32'h0019_7231, 32'h0, 32'h0020_8101);
    roll("R5 R8 year 99 wday 7", 32'h0023_5959, 32'h0099_F231, 32'h0, 32'h0000_2101);
  endtask

  initial begin
    t_reset();
    t_ignore();
    t_freeze();
    t_gated();
    t_time_carry();
    t_months();
    t_feb();
    t_year();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule